// File: doc/BRIEF.md
# Task-Indexed Page Mapper

This block translates the 16-bit addresses of an 8-bit CPU into a 24-bit physical address. The CPU address is split into an 8-bit page number and an 8-bit offset. The page number is joined with a 2-bit task number to index one shared table of 1024 page-frame entries. The selected 16-bit frame number becomes the upper part of the physical address. The offset passes through unchanged.

Each task owns a fixed slice of 256 entries. The slice is chosen by placing the task number on the top index bits, so no adder sits in the lookup path. A context switch rewrites only the task register and leaves every table entry in place. A configuration port loads table entries and the task register. A bypass input sends the CPU address straight through with zero upper bits, so software can boot before it fills the table. There is no fault output: every address translates to some physical address.

Top module: `task_page_mapper`

## Requirements
- R1: `phys_addr[7:0]` always equals `cpu_addr[7:0]`. When bypass is low, `phys_addr[23:8]` equals the table entry that was selected.
- R2: The table index is the task register in bits 9:8 joined with `cpu_addr[15:8]` in bits 7:0.
- R3: After reset the task register is 0. Entry i of task 0 (index 0..255) holds i. Every entry of tasks 1..3 holds 0.
- R4: When `cfg_we` is 1 and `cfg_sel` is 0, `cfg_data` is written to the entry at `cfg_addr` on the next rising edge. Translation during the write cycle uses the old entry.
- R5: When `cfg_we` is 1 and `cfg_sel` is 1, the task register loads `cfg_data[1:0]` on the next rising edge. The other data bits and `cfg_addr` are ignored, and no table entry changes.
- R6: Changing the task register never alters the table. Switching back to a task restores its earlier mapping.
- R7: While `bypass` is 1, `phys_addr` equals {8'h00, `cpu_addr`}. Configuration writes issued during bypass still take effect.
- R8: Translation is combinational. `phys_addr` follows a change of `cpu_addr` or `bypass` within the same cycle.
- R9: While `cfg_we` is 0, neither the task register nor any entry changes, whatever `cfg_sel`, `cfg_addr` and `cfg_data` carry.
- R10: A table write changes only the addressed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| cpu_addr | input | 16 | CPU logical address |
| bypass | input | 1 | 1 = pass the address through untranslated |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = write a table entry, 1 = load the task register |
| cfg_addr | input | 10 | Table index for an entry write |
| cfg_data | input | 16 | Frame number to write. Bits 1:0 carry the task number on a task load. |
| phys_addr | output | 24 | Translated physical address |

## Verification
A corrupt entry shows up as a wrong upper field of `phys_addr`. It appears in the same cycle that an address in the affected page is presented. A wrong task register shifts every lookup into another task's slice, so the next translated address is already wrong. To find a stray write, the bench presents addresses near the written entry after each update. It also switches tasks away and back, which exposes any damage to the mapping of the task that was switched out.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int unsigned VA_W   = 16;
  localparam int unsigned OFS_W  = 8;
  localparam int unsigned TASK_W = 2;
  localparam int unsigned FRM_W  = 16;
  localparam int unsigned PG_W   = VA_W - OFS_W;
  localparam int unsigned IDX_W  = TASK_W + PG_W;
  localparam int unsigned PA_W   = FRM_W + OFS_W;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [FRM_W-1:0]  frame_t;
  typedef logic [TASK_W-1:0] task_t;
endpackage

// File: rtl/tpm_rst_sync.sv
module tpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tpm_cfg_decode.sv
module tpm_cfg_decode
  import tpm_pkg::*;
(
  input  logic   rst_n,
  input  logic   cfg_we,
  input  logic   cfg_sel,
  input  idx_t   cfg_addr,
  input  frame_t cfg_data,
  output logic   tbl_we,
  output idx_t   tbl_addr,
  output frame_t tbl_data,
  output logic   task_we,
  output task_t  task_d
);
  always_comb begin
    tbl_we   = cfg_we & ~cfg_sel & rst_n;
    task_we  = cfg_we &  cfg_sel & rst_n;
    tbl_addr = cfg_addr;
    tbl_data = cfg_data;
    task_d   = cfg_data[TASK_W-1:0];
  end
endmodule

// File: rtl/tpm_task_reg.sv
module tpm_task_reg
  import tpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  task_t load_val,
  output task_t task_q
);
  task_t task_nx;

  always_comb begin
    task_nx = task_q;
    if (load_en) task_nx = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) task_q <= '0;
    else        task_q <= task_nx;
  end

  assert_task_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> task_q == $past(load_val));

  assert_task_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(task_q));
endmodule

// File: rtl/tpm_map_table.sv
module tpm_map_table
  import tpm_pkg::*;
#(
  parameter int unsigned DEPTH = 2**IDX_W,
  parameter int unsigned SLICE = 2**PG_W
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  idx_t   wr_addr,
  input  frame_t wr_data,
  input  idx_t   rd_idx,
  output frame_t rd_data
);
  logic [DEPTH-1:0][FRM_W-1:0] ent_flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam frame_t RST_VAL = (g < SLICE) ? FRM_W'(g) : '0;
    frame_t ent_q;
    frame_t ent_d;
    logic   hit;

    always_comb begin
      hit   = wr_en && (wr_addr == IDX_W'(g));
      ent_d = hit ? wr_data : ent_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= RST_VAL;
      else        ent_q <= ent_d;
    end

    assign ent_flat[g] = ent_q;
  end

  assign rd_data = ent_flat[rd_idx];

  assert_entry_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_flat[$past(wr_addr)] == $past(wr_data));

  assert_quiet_table_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ent_flat));
endmodule

// File: rtl/task_page_mapper.sv
module task_page_mapper
  import tpm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VA_W-1:0]    cpu_addr,
  input  logic               bypass,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [IDX_W-1:0]   cfg_addr,
  input  logic [FRM_W-1:0]   cfg_data,
  output logic [PA_W-1:0]    phys_addr
);
  logic   rst_s_n;
  logic   tbl_we;
  idx_t   tbl_addr;
  frame_t tbl_data;
  logic   task_we;
  task_t  task_d;
  task_t  task_q;
  idx_t   look_idx;
  frame_t frame;

  tpm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  tpm_cfg_decode u_dec (
    .rst_n    (rst_s_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .tbl_we   (tbl_we),
    .tbl_addr (tbl_addr),
    .tbl_data (tbl_data),
    .task_we  (task_we),
    .task_d   (task_d)
  );

  tpm_task_reg u_task (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load_en  (task_we),
    .load_val (task_d),
    .task_q   (task_q)
  );

  assign look_idx = {task_q, cpu_addr[VA_W-1:OFS_W]};

  tpm_map_table u_tbl (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_data),
    .rd_idx  (look_idx),
    .rd_data (frame)
  );

  always_comb begin
    if (bypass) phys_addr = {{(PA_W-VA_W){1'b0}}, cpu_addr};
    else        phys_addr = {frame, cpu_addr[OFS_W-1:0]};
  end

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]);

  assert_bypass_flat_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    bypass |-> phys_addr[PA_W-1:VA_W] == '0);

  assert_no_table_on_task_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    task_we |-> !tbl_we);
endmodule

// File: tb/task_page_mapper_tb.sv
module task_page_mapper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        bypass;
  logic        cfg_we;
  logic        cfg_sel;
  logic [9:0]  cfg_addr;
  logic [15:0] cfg_data;
  logic [23:0] phys_addr;

  int n_run;
  int n_fail;
  bit done;

  task_page_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .bypass(bypass),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .phys_addr(phys_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [23:0] exp);
    n_run++;
    if (phys_addr !== exp) begin
      n_fail++;
      $display("FAIL %s: phys_addr=%06h expected %06h", req, phys_addr, exp);
    end
  endtask

  task automatic look(input logic [15:0] a, input string req, input logic [23:0] exp);
    cpu_addr = a;
    #1;
    check(req, exp);
  endtask

  task automatic cfg(input logic sel, input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset_state;
    look(16'h1234, "R3", 24'h001234);
    look(16'hFF00, "R3", 24'h00FF00);
    cfg(1'b1, 10'h000, 16'h0001);
    look(16'h1234, "R3", 24'h000034);
    cfg(1'b1, 10'h000, 16'h0003);
    look(16'hFFAA, "R3", 24'h0000AA);
    cfg(1'b1, 10'h000, 16'h0000);
  endtask

  task automatic t_write_timing;
    @(negedge clk);
    cpu_addr = 16'h1234;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_addr = 10'h012; cfg_data = 16'hABCD;
    #1;
    check("R4 old value in write cycle", 24'h001234);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R4 new value after edge", 24'hABCD34);
    look(16'h1334, "R10 neighbour untouched", 24'h001334);
    look(16'h1134, "R10 neighbour untouched", 24'h001134);
  endtask

  task automatic t_task_switch;
    cfg(1'b1, 10'h013, 16'hFFFE);
    look(16'h1234, "R5 task 2 from data[1:0]", 24'h000034);
    look(16'h1334, "R5 cfg_addr ignored on task load", 24'h000034);
    cfg(1'b0, 10'h2FF, 16'h7E55);
    look(16'hFF01, "R2 task 2 index", 24'h7E5501);
    cfg(1'b1, 10'h000, 16'h0000);
    look(16'h1234, "R6 task 0 restored", 24'hABCD34);
    look(16'hFF01, "R2 task 0 not aliased", 24'h00FF01);
    cfg(1'b1, 10'h000, 16'h0002);
    look(16'hFF01, "R6 task 2 restored", 24'h7E5501);
    cfg(1'b1, 10'h000, 16'h0000);
  endtask

  task automatic t_bypass;
    bypass = 1'b1;
    look(16'h1234, "R7 bypass", 24'h001234);
    look(16'hBEEF, "R8 same-cycle follow", 24'h00BEEF);
    cfg(1'b0, 10'h0BE, 16'h4242);
    look(16'hBEEF, "R7 bypass ignores table", 24'h00BEEF);
    bypass = 1'b0;
    #1;
    check("R7 write during bypass kept", 24'h4242EF);
  endtask

  task automatic t_idle_port;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 1'b1; cfg_addr = 10'h012; cfg_data = 16'h0003;
    @(negedge clk);
    cfg_sel = 1'b0; cfg_data = 16'h1111;
    @(negedge clk);
    look(16'h1234, "R9 idle port task and entry", 24'hABCD34);
    look(16'h0077, "R1 offset pass", 24'h000077);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; cpu_addr = '0; bypass = 1'b0;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_addr = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state;
    t_write_timing;
    t_task_switch;
    t_bypass;
    t_idle_port;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule